// File: doc/BRIEF.md
# Timestamp-Ordered L1 Consistency Unit

This unit is the client half of a lease-based coherence scheme for one core's data cache. Each line of a small direct-mapped array carries a MESI-style state (Invalid, Shared, Modified), a tag, a data word and a logical lease given as a pair of timestamps, `wts` (the version's write time) and `rts` (the last time at which the line may be read). Ordering between cores comes from these logical timestamps and not from physical time. The unit keeps three core timestamp registers: a lower bound for new operations, the largest timestamp used so far, and the value captured at the last release. Fences, acquires and releases are only moves among these three registers.

The core presents one operation at a time: load, store, fence, acquire, release, load-reserved or store-conditional. The unit decides whether the local copy serves the operation, stamps it, and creates new versions for stores. When the local copy cannot serve it, the unit sends a shared or exclusive request to the manager with a timestamp. The manager replies with a lease grant, and the unit then finishes the operation. The manager may also send a writeback request. The unit answers it with the line's data and lease and lowers the line's state. Store-conditional succeeds when the line's version timestamp still equals the one seen at load-reserved. This comparison prevents two cores from livelocking when they contend for a reservation.

The controller has five states. `ST_IDLE` accepts a core request and moves to `ST_EXEC`; if a writeback request is present it takes that first and moves to `ST_WB`. `ST_EXEC` evaluates the latched operation and moves to `ST_RESP` when it completes locally, or to `ST_MISS` when the manager must be asked. `ST_MISS` holds the request until a grant arrives, installs the line and returns to `ST_EXEC`; a writeback request in `ST_MISS` moves to `ST_WB`. `ST_RESP` presents the response for one cycle and returns to `ST_IDLE`. `ST_WB` presents the writeback reply for one cycle and returns to the state it came from.

Top module: `tsc_l1_unit`

## Requirements
- R1: After reset every line is Invalid, all three timestamp registers are 0, `req_ready` is 1 and `mreq_valid` is 0.
- R2: A store (op code 1) to a line held Modified writes the store data and sets the line's `wts` and `rts` both to max(ts_min, rts+1). That value is returned on `resp_ts`; a line granted with lease [0,0] while ts_min is 0 becomes [1,1].
- R3: A store, load-reserved or store-conditional on a line that is not Modified (or whose tag differs) raises `mreq_valid` with `mreq_excl`=1 and `mreq_ts`=ts_min. The request stays steady until `grant_valid`, after which the operation completes against the granted line.
- R4: A load (op code 0) to a valid line with matching tag is served locally with no manager request when its read timestamp max(ts_min, wts) is at most `rts`, or when the line is Modified. It returns the line data with the read timestamp on `resp_ts`.
- R5: A load that misses, or whose read timestamp exceeds `rts` on a Shared line, raises a shared request (`mreq_excl`=0). The request carries the read timestamp, or ts_min on a tag miss, and the load returns the granted data.
- R6: ts_max never decreases and after each load, store, load-reserved or successful store-conditional equals the maximum of its old value and the timestamp that operation used.
- R7: A fence (op code 2) copies ts_max into ts_min.
- R8: A release (op code 4) copies ts_max into ts_rel; an acquire (op code 3) copies ts_rel into ts_min.
- R9: Load-reserved (op code 5) obtains the line Modified, returns its data with timestamp max(ts_min, wts), and records the address and the line's `wts` as the reservation.
- R10: Store-conditional (op code 6) to the reserved address on a Modified line whose `wts` equals the recorded version writes a new version as in R2 and returns data 0. This also holds after a downgrade and re-grant of the same version.
- R11: Store-conditional with no reservation, another address, or a changed `wts` returns data 1. It writes nothing and leaves ts_max unchanged; the reservation is cleared by any completed store-conditional.
- R12: A writeback request that matches a valid line replies with `wb_resp_hit`=1, the line's data, `wts` and `rts`. The line goes from Modified to Shared, or to Invalid when `wb_req_recall` is 1; a request matching no valid line replies with `wb_resp_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_op | input | 3 | Operation code (0 load, 1 store, 2 fence, 3 acquire, 4 release, 5 load-reserved, 6 store-conditional) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted at this edge when valid |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DW | Load data, or store-conditional result (0 success, 1 failure) |
| resp_ts | output | TSW | Timestamp the operation used |
| ts_min | output | TSW | Lower bound timestamp register |
| ts_max | output | TSW | Largest timestamp used so far |
| ts_rel | output | TSW | Timestamp captured at the last release |
| mreq_valid | output | 1 | Manager request pending |
| mreq_excl | output | 1 | 1 exclusive, 0 shared |
| mreq_addr | output | AW | Requested address |
| mreq_ts | output | TSW | Timestamp carried by the request |
| grant_valid | input | 1 | Lease grant strobe |
| grant_excl | input | 1 | Grant is exclusive |
| grant_data | input | DW | Granted data |
| grant_wts | input | TSW | Granted version timestamp |
| grant_rts | input | TSW | Granted lease end |
| wb_req_valid | input | 1 | Writeback request strobe |
| wb_req_addr | input | AW | Writeback address |
| wb_req_recall | input | 1 | 1 invalidate, 0 downgrade to Shared |
| wb_resp_valid | output | 1 | One-cycle writeback reply strobe |
| wb_resp_hit | output | 1 | A valid line matched |
| wb_resp_data | output | DW | Line data |
| wb_resp_wts | output | TSW | Line version timestamp |
| wb_resp_rts | output | TSW | Line lease end |

## Verification
The bench first raises ts_min with a fence and an acquire. It then reloads a Shared line whose lease has expired for that new lower bound. A unit that compared against physical order, or stamped with the old bound, would hit locally instead of renewing, or would carry the wrong timestamp. A store to a freshly granted lease checks the max(ts_min, rts+1) rule; an off-by-one design would produce [0,0] or [2,2]. For store-conditional the bench covers a version bumped by another core while the reservation was held, which a design keyed on a reservation flag alone would wrongly accept. It also covers a downgrade followed by a re-grant of the same version, which a design that drops the reservation on downgrade would wrongly reject. A store-conditional repeated without a new load-reserved must fail and leave the data unchanged. Writebacks check both downgrade and recall, and a request for an absent line.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_M = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_STORE   = 3'd1,
        OP_FENCE   = 3'd2,
        OP_ACQUIRE = 3'd3,
        OP_RELEASE = 3'd4,
        OP_LR      = 3'd5,
        OP_SC      = 3'd6,
        OP_NONE    = 3'd7
    } core_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_EXEC = 3'd1,
        ST_MISS = 3'd2,
        ST_RESP = 3'd3,
        ST_WB   = 3'd4
    } ctl_st_e;

endpackage

// File: rtl/tsc_line_array.sv
module tsc_line_array
    import tsc_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int TAGW   = 6,
    parameter int TSW    = 16,
    parameter int DW     = 32,
    localparam int IDXW  = $clog2(NLINES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  line_st_e        wst,
    input  logic [TAGW-1:0] wtag,
    input  logic [TSW-1:0]  wwts,
    input  logic [TSW-1:0]  wrts,
    input  logic [DW-1:0]   wdata,
    input  logic [IDXW-1:0] aidx,
    output line_st_e        ast,
    output logic [TAGW-1:0] atag,
    output logic [TSW-1:0]  awts,
    output logic [TSW-1:0]  arts,
    output logic [DW-1:0]   adata,
    input  logic [IDXW-1:0] bidx,
    output line_st_e        bst,
    output logic [TAGW-1:0] btag,
    output logic [TSW-1:0]  bwts,
    output logic [TSW-1:0]  brts,
    output logic [DW-1:0]   bdata
);

    line_st_e        st_q   [NLINES];
    logic [TAGW-1:0] tag_q  [NLINES];
    logic [TSW-1:0]  wts_q  [NLINES];
    logic [TSW-1:0]  rts_q  [NLINES];
    logic [DW-1:0]   data_q [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]   <= LN_I;
                tag_q[g]  <= '0;
                wts_q[g]  <= '0;
                rts_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (we && widx == IDXW'(g)) begin
                st_q[g]   <= wst;
                tag_q[g]  <= wtag;
                wts_q[g]  <= wwts;
                rts_q[g]  <= wrts;
                data_q[g] <= wdata;
            end
        end
    end

    assign ast   = st_q[aidx];
    assign atag  = tag_q[aidx];
    assign awts  = wts_q[aidx];
    assign arts  = rts_q[aidx];
    assign adata = data_q[aidx];
    assign bst   = st_q[bidx];
    assign btag  = tag_q[bidx];
    assign bwts  = wts_q[bidx];
    assign brts  = rts_q[bidx];
    assign bdata = data_q[bidx];

    // A written line never carries a lease that ends before its version.
    assert_lease_order_R2: assert property (@(posedge clk) disable iff (rst)
        we && wst != LN_I |=> rts_q[$past(widx)] >= wts_q[$past(widx)]);

endmodule

// File: rtl/tsc_ts_regs.sv
module tsc_ts_regs #(
    parameter int TSW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           do_fence,
    input  logic           do_acquire,
    input  logic           do_release,
    input  logic           bump_en,
    input  logic [TSW-1:0] bump_ts,
    output logic [TSW-1:0] tsmin,
    output logic [TSW-1:0] tsmax,
    output logic [TSW-1:0] tsrel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tsmin <= '0;
            tsmax <= '0;
            tsrel <= '0;
        end else begin
            if (bump_en && bump_ts > tsmax) tsmax <= bump_ts;
            if (do_fence)   tsmin <= tsmax;
            if (do_acquire) tsmin <= tsrel;
            if (do_release) tsrel <= tsmax;
        end
    end

    assert_max_monotonic_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tsmax >= $past(tsmax));

    assert_bump_reaches_R6: assert property (@(posedge clk) disable iff (rst)
        bump_en |=> tsmax >= $past(bump_ts));

    assert_fence_copy_R7: assert property (@(posedge clk) disable iff (rst)
        do_fence |=> tsmin == $past(tsmax));

    assert_release_copy_R8: assert property (@(posedge clk) disable iff (rst)
        do_release |=> tsrel == $past(tsmax));

    assert_min_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        tsmin <= tsmax && tsrel <= tsmax);

endmodule

// File: rtl/tsc_l1_unit.sv
module tsc_l1_unit
    import tsc_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int TSW    = 16,
    parameter int NLINES = 4,
    localparam int IDXW  = $clog2(NLINES),
    localparam int TAGW  = AW - IDXW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic [2:0]     req_op,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           req_ready,
    output logic           resp_valid,
    output logic [DW-1:0]  resp_data,
    output logic [TSW-1:0] resp_ts,
    output logic [TSW-1:0] ts_min,
    output logic [TSW-1:0] ts_max,
    output logic [TSW-1:0] ts_rel,
    output logic           mreq_valid,
    output logic           mreq_excl,
    output logic [AW-1:0]  mreq_addr,
    output logic [TSW-1:0] mreq_ts,
    input  logic           grant_valid,
    input  logic           grant_excl,
    input  logic [DW-1:0]  grant_data,
    input  logic [TSW-1:0] grant_wts,
    input  logic [TSW-1:0] grant_rts,
    input  logic           wb_req_valid,
    input  logic [AW-1:0]  wb_req_addr,
    input  logic           wb_req_recall,
    output logic           wb_resp_valid,
    output logic           wb_resp_hit,
    output logic [DW-1:0]  wb_resp_data,
    output logic [TSW-1:0] wb_resp_wts,
    output logic [TSW-1:0] wb_resp_rts
);

    function automatic logic [TSW-1:0] tmax(input logic [TSW-1:0] a, input logic [TSW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    ctl_st_e        st_q, st_n, ret_q, ret_n;
    core_op_e       op_q, op_n;
    logic [AW-1:0]  addr_q, addr_n;
    logic [DW-1:0]  wdata_q, wdata_n;
    logic           mexcl_q, mexcl_n;
    logic [TSW-1:0] mts_q, mts_n;
    logic [DW-1:0]  rdata_q, rdata_n;
    logic [TSW-1:0] rts_out_q, rts_out_n;
    logic           resv_v_q, resv_v_n;
    logic [AW-1:0]  resv_a_q, resv_a_n;
    logic [TSW-1:0] resv_w_q, resv_w_n;
    logic           wbhit_q, wbhit_n, wbrec_q, wbrec_n;
    logic [AW-1:0]  wbaddr_q, wbaddr_n;
    logic [DW-1:0]  wbdata_q, wbdata_n;
    logic [TSW-1:0] wbwts_q, wbwts_n, wbrts_q, wbrts_n;

    logic            arr_we;
    logic [IDXW-1:0] arr_widx;
    line_st_e        arr_wst;
    logic [TAGW-1:0] arr_wtag;
    logic [TSW-1:0]  arr_wwts, arr_wrts;
    logic [DW-1:0]   arr_wdata;
    logic [IDXW-1:0] bidx;
    line_st_e        st_a, st_b;
    logic [TAGW-1:0] tag_a, tag_b;
    logic [TSW-1:0]  wts_a, rts_a, wts_b, rts_b;
    logic [DW-1:0]   data_a, data_b;

    logic            do_fence, do_acquire, do_release, bump_en;
    logic [TSW-1:0]  bump_ts;
    logic [TSW-1:0]  tsmin, tsmax, tsrel;

    logic            tag_hit, is_mod, ld_hit, wb_take, wb_match;
    logic [TSW-1:0]  rd_ts, new_ver;

    assign bidx = (st_q == ST_WB) ? wbaddr_q[IDXW-1:0] : wb_req_addr[IDXW-1:0];

    tsc_line_array #(.NLINES(NLINES), .TAGW(TAGW), .TSW(TSW), .DW(DW)) u_lines (
        .clk(clk), .rst(rst),
        .we(arr_we), .widx(arr_widx), .wst(arr_wst), .wtag(arr_wtag),
        .wwts(arr_wwts), .wrts(arr_wrts), .wdata(arr_wdata),
        .aidx(addr_q[IDXW-1:0]), .ast(st_a), .atag(tag_a), .awts(wts_a),
        .arts(rts_a), .adata(data_a),
        .bidx(bidx), .bst(st_b), .btag(tag_b), .bwts(wts_b),
        .brts(rts_b), .bdata(data_b)
    );

    tsc_ts_regs #(.TSW(TSW)) u_ts (
        .clk(clk), .rst(rst),
        .do_fence(do_fence), .do_acquire(do_acquire), .do_release(do_release),
        .bump_en(bump_en), .bump_ts(bump_ts),
        .tsmin(tsmin), .tsmax(tsmax), .tsrel(tsrel)
    );

    // Lookup terms for the latched core request.
    assign tag_hit = (st_a != LN_I) && (tag_a == addr_q[AW-1:IDXW]);
    assign is_mod  = tag_hit && (st_a == LN_M);
    assign rd_ts   = tag_hit ? tmax(tsmin, wts_a) : tsmin;
    assign new_ver = tmax(tsmin, rts_a + TSW'(1));
    assign ld_hit  = tag_hit && (is_mod || rd_ts <= rts_a);
    assign wb_match = (st_b != LN_I) && (tag_b == wb_req_addr[AW-1:IDXW]);

    // State register.
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_n;
    end

    // Next state, array write and timestamp controls.
    always_comb begin
        st_n = st_q;     ret_n = ret_q;   op_n = op_q;
        addr_n = addr_q; wdata_n = wdata_q;
        mexcl_n = mexcl_q; mts_n = mts_q;
        rdata_n = rdata_q; rts_out_n = rts_out_q;
        resv_v_n = resv_v_q; resv_a_n = resv_a_q; resv_w_n = resv_w_q;
        wbhit_n = wbhit_q; wbrec_n = wbrec_q; wbaddr_n = wbaddr_q;
        wbdata_n = wbdata_q; wbwts_n = wbwts_q; wbrts_n = wbrts_q;
        arr_we = 1'b0; arr_widx = addr_q[IDXW-1:0]; arr_wst = st_a;
        arr_wtag = addr_q[AW-1:IDXW]; arr_wwts = wts_a; arr_wrts = rts_a;
        arr_wdata = data_a;
        do_fence = 1'b0; do_acquire = 1'b0; do_release = 1'b0;
        bump_en = 1'b0; bump_ts = '0;
        wb_take = 1'b0;

        unique case (st_q)
            ST_IDLE: begin
                if (wb_req_valid) begin
                    wb_take = 1'b1;
                    ret_n   = ST_IDLE;
                    st_n    = ST_WB;
                end else if (req_valid) begin
                    op_n    = core_op_e'(req_op);
                    addr_n  = req_addr;
                    wdata_n = req_wdata;
                    st_n    = ST_EXEC;
                end
            end
            ST_EXEC: begin
                st_n = ST_RESP;
                unique case (op_q)
                    OP_LOAD, OP_LR: begin
                        if ((op_q == OP_LOAD && ld_hit) || (op_q == OP_LR && is_mod)) begin
                            if (rd_ts > rts_a) begin
                                arr_we = 1'b1;
                                arr_wrts = rd_ts;
                            end
                            rdata_n = data_a;
                            rts_out_n = rd_ts;
                            bump_en = 1'b1;
                            bump_ts = rd_ts;
                            if (op_q == OP_LR) begin
                                resv_v_n = 1'b1;
                                resv_a_n = addr_q;
                                resv_w_n = wts_a;
                            end
                        end else begin
                            mexcl_n = (op_q == OP_LR);
                            mts_n   = (op_q == OP_LR) ? tsmin : rd_ts;
                            st_n    = ST_MISS;
                        end
                    end
                    OP_STORE: begin
                        if (is_mod) begin
                            arr_we = 1'b1;
                            arr_wwts = new_ver;
                            arr_wrts = new_ver;
                            arr_wdata = wdata_q;
                            rts_out_n = new_ver;
                            rdata_n = '0;
                            bump_en = 1'b1;
                            bump_ts = new_ver;
                        end else begin
                            mexcl_n = 1'b1;
                            mts_n   = tsmin;
                            st_n    = ST_MISS;
                        end
                    end
                    OP_SC: begin
                        if (!resv_v_q || resv_a_q != addr_q) begin
                            rdata_n = DW'(1);
                            rts_out_n = tsmax;
                            resv_v_n = 1'b0;
                        end else if (!is_mod) begin
                            mexcl_n = 1'b1;
                            mts_n   = tsmin;
                            st_n    = ST_MISS;
                        end else if (wts_a == resv_w_q) begin
                            arr_we = 1'b1;
                            arr_wwts = new_ver;
                            arr_wrts = new_ver;
                            arr_wdata = wdata_q;
                            rdata_n = '0;
                            rts_out_n = new_ver;
                            bump_en = 1'b1;
                            bump_ts = new_ver;
                            resv_v_n = 1'b0;
                        end else begin
                            rdata_n = DW'(1);
                            rts_out_n = tsmax;
                            resv_v_n = 1'b0;
                        end
                    end
                    OP_FENCE: begin
                        do_fence = 1'b1;
                        rdata_n = '0;
                        rts_out_n = tsmax;
                    end
                    OP_ACQUIRE: begin
                        do_acquire = 1'b1;
                        rdata_n = '0;
                        rts_out_n = tsrel;
                    end
                    OP_RELEASE: begin
                        do_release = 1'b1;
                        rdata_n = '0;
                        rts_out_n = tsmax;
                    end
                    default: begin
                        rdata_n = '0;
                        rts_out_n = tsmax;
                    end
                endcase
            end
            ST_MISS: begin
                if (wb_req_valid) begin
                    wb_take = 1'b1;
                    ret_n   = ST_MISS;
                    st_n    = ST_WB;
                end else if (grant_valid) begin
                    arr_we = 1'b1;
                    arr_wst = grant_excl ? LN_M : LN_S;
                    arr_wwts = grant_wts;
                    arr_wrts = grant_rts;
                    arr_wdata = grant_data;
                    st_n = ST_EXEC;
                end
            end
            ST_RESP: st_n = ST_IDLE;
            ST_WB:   st_n = ret_q;
            default: st_n = ST_IDLE;
        endcase

        // Writeback servicing shares the single array write port.
        if (wb_take) begin
            wbaddr_n = wb_req_addr;
            wbrec_n  = wb_req_recall;
            wbhit_n  = wb_match;
            wbdata_n = data_b;
            wbwts_n  = wts_b;
            wbrts_n  = rts_b;
            if (wb_match && (wb_req_recall || st_b == LN_M)) begin
                arr_we    = 1'b1;
                arr_widx  = wb_req_addr[IDXW-1:0];
                arr_wst   = wb_req_recall ? LN_I : LN_S;
                arr_wtag  = tag_b;
                arr_wwts  = wts_b;
                arr_wrts  = rts_b;
                arr_wdata = data_b;
            end
        end
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            ret_q <= ST_IDLE; op_q <= OP_NONE; addr_q <= '0; wdata_q <= '0;
            mexcl_q <= 1'b0; mts_q <= '0; rdata_q <= '0; rts_out_q <= '0;
            resv_v_q <= 1'b0; resv_a_q <= '0; resv_w_q <= '0;
            wbhit_q <= 1'b0; wbrec_q <= 1'b0; wbaddr_q <= '0;
            wbdata_q <= '0; wbwts_q <= '0; wbrts_q <= '0;
        end else begin
            ret_q <= ret_n; op_q <= op_n; addr_q <= addr_n; wdata_q <= wdata_n;
            mexcl_q <= mexcl_n; mts_q <= mts_n; rdata_q <= rdata_n;
            rts_out_q <= rts_out_n;
            resv_v_q <= resv_v_n; resv_a_q <= resv_a_n; resv_w_q <= resv_w_n;
            wbhit_q <= wbhit_n; wbrec_q <= wbrec_n; wbaddr_q <= wbaddr_n;
            wbdata_q <= wbdata_n; wbwts_q <= wbwts_n; wbrts_q <= wbrts_n;
        end
    end

    // Outputs.
    always_comb begin
        req_ready     = (st_q == ST_IDLE) && !wb_req_valid;
        resp_valid    = (st_q == ST_RESP);
        resp_data     = rdata_q;
        resp_ts       = rts_out_q;
        mreq_valid    = (st_q == ST_MISS);
        mreq_excl     = mexcl_q;
        mreq_addr     = addr_q;
        mreq_ts       = mts_q;
        wb_resp_valid = (st_q == ST_WB);
        wb_resp_hit   = wbhit_q;
        wb_resp_data  = wbdata_q;
        wb_resp_wts   = wbwts_q;
        wb_resp_rts   = wbrts_q;
        ts_min        = tsmin;
        ts_max        = tsmax;
        ts_rel        = tsrel;
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> !mreq_valid && !resp_valid && !wb_resp_valid);

    assert_hold_request_R3: assert property (@(posedge clk) disable iff (rst)
        mreq_valid && !grant_valid && !wb_req_valid
        |=> mreq_valid && $stable(mreq_ts) && $stable(mreq_excl) && $stable(mreq_addr));

    assert_load_hit_local_R4: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_EXEC && op_q == OP_LOAD && ld_hit |=> !mreq_valid && resp_valid);

    assert_sc_fail_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        resp_valid && op_q == OP_SC && resp_data != '0 |-> tsmax == $past(tsmax));

    assert_wb_downgrade_R12: assert property (@(posedge clk) disable iff (rst)
        wb_resp_valid && wb_resp_hit |-> st_b != LN_M);

    assert_wb_recall_R12: assert property (@(posedge clk) disable iff (rst)
        wb_resp_valid && wb_resp_hit && wbrec_q |-> st_b == LN_I);

endmodule

// File: tb/tsc_l1_unit_test.sv
module tsc_l1_unit_test;
    localparam int AW = 8, DW = 32, TSW = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0; logic [2:0] req_op = 0;
    logic [AW-1:0] req_addr = 0; logic [DW-1:0] req_wdata = 0;
    logic req_ready, resp_valid; logic [DW-1:0] resp_data; logic [TSW-1:0] resp_ts;
    logic [TSW-1:0] ts_min, ts_max, ts_rel;
    logic mreq_valid, mreq_excl; logic [AW-1:0] mreq_addr; logic [TSW-1:0] mreq_ts;
    logic grant_valid = 0, grant_excl = 0; logic [DW-1:0] grant_data = 0;
    logic [TSW-1:0] grant_wts = 0, grant_rts = 0;
    logic wb_req_valid = 0, wb_req_recall = 0; logic [AW-1:0] wb_req_addr = 0;
    logic wb_resp_valid, wb_resp_hit; logic [DW-1:0] wb_resp_data;
    logic [TSW-1:0] wb_resp_wts, wb_resp_rts;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    tsc_l1_unit uut (.*);

    localparam logic [AW-1:0] A = 8'h04, B = 8'h05, C = 8'h06, E = 8'h07;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic serve(input bit excl, input logic [TSW-1:0] ts, input string tag,
                         input logic [TSW-1:0] w, input logic [TSW-1:0] r, input logic [DW-1:0] d);
        int n = 0;
        while (!mreq_valid && n < 50) begin @(negedge clk); n++; end
        chk(mreq_valid, {tag, " request raised"}, mreq_valid, 1);
        chk(mreq_excl == excl, {tag, " request kind"}, mreq_excl, excl);
        chk(mreq_ts == ts, {tag, " request ts"}, mreq_ts, ts);
        grant_valid = 1; grant_excl = excl; grant_wts = w; grant_rts = r; grant_data = d;
        @(negedge clk);
        grant_valid = 0;
    endtask

    task automatic get_resp(output logic [DW-1:0] d, output logic [TSW-1:0] ts, output bit saw_req);
        int n = 0;
        saw_req = 0;
        while (!resp_valid && n < 50) begin
            if (mreq_valid) saw_req = 1;
            @(negedge clk); n++;
        end
        d = resp_data; ts = resp_ts;
    endtask

    task automatic wb(input logic [AW-1:0] a, input bit recall, output bit hit,
                      output logic [DW-1:0] d, output logic [TSW-1:0] w, output logic [TSW-1:0] r);
        int n = 0;
        @(negedge clk);
        wb_req_valid = 1; wb_req_addr = a; wb_req_recall = recall;
        @(negedge clk);
        wb_req_valid = 0;
        while (!wb_resp_valid && n < 50) begin @(negedge clk); n++; end
        hit = wb_resp_hit; d = wb_resp_data; w = wb_resp_wts; r = wb_resp_rts;
    endtask

    task automatic t_reset;
        chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
        chk(mreq_valid == 0, "R1 no request after reset", mreq_valid, 0);
        chk(ts_min == 0 && ts_max == 0 && ts_rel == 0, "R1 timestamps zero", ts_max, 0);
    endtask

    task automatic t_store_first;
        logic [DW-1:0] d; logic [TSW-1:0] ts, w, r; bit s, h;
        issue(1, A, 32'hA1);
        serve(1, 0, "R3 store miss", 0, 0, 0);
        get_resp(d, ts, s);
        chk(ts == 1, "R2 store version ts", ts, 1);
        chk(ts_max == 1 && ts_min == 0, "R6 ts_max after store", ts_max, 1);
        wb(A, 0, h, d, w, r);
        chk(h && d == 32'hA1, "R12 writeback data", d, 32'hA1);
        chk(w == 1 && r == 1, "R2 new version lease", {w, r}, {16'd1, 16'd1});
    endtask

    task automatic t_loads;
        logic [DW-1:0] d; logic [TSW-1:0] ts; bit s;
        issue(0, B, 0);
        serve(0, 0, "R5 load miss", 1, 11, 32'hB0);
        get_resp(d, ts, s);
        chk(d == 32'hB0 && ts == 1, "R5 load miss result", {d, ts}, {32'hB0, 16'd1});
        issue(0, B, 0);
        get_resp(d, ts, s);
        chk(!s && d == 32'hB0 && ts == 1, "R4 load hit local", {s, d, ts}, {1'b0, 32'hB0, 16'd1});
        issue(0, A, 0);
        get_resp(d, ts, s);
        chk(!s && d == 32'hA1, "R4 hit on downgraded line", d, 32'hA1);
    endtask

    task automatic t_order_regs;
        logic [DW-1:0] d; logic [TSW-1:0] ts; bit s;
        issue(2, 0, 0);
        get_resp(d, ts, s);
        chk(ts_min == 1, "R7 fence copies ts_max", ts_min, 1);
        issue(1, A, 32'hA2);
        serve(1, 1, "R3 store on shared line", 12, 12, 32'hA1);
        get_resp(d, ts, s);
        chk(ts == 13 && ts_max == 13, "R2 store after renewal", ts, 13);
        issue(4, 0, 0);
        get_resp(d, ts, s);
        chk(ts_rel == 13 && ts_min == 1, "R8 release", ts_rel, 13);
        issue(3, 0, 0);
        get_resp(d, ts, s);
        chk(ts_min == 13, "R8 acquire", ts_min, 13);
        issue(0, B, 0);
        serve(0, 13, "R5 lease expired renewal", 1, 23, 32'hB0);
        get_resp(d, ts, s);
        chk(d == 32'hB0 && ts == 13, "R5 renewed load", ts, 13);
    endtask

    task automatic t_lrsc_ok;
        logic [DW-1:0] d; logic [TSW-1:0] ts, w, r; bit s, h;
        issue(5, C, 0);
        serve(1, 13, "R9 load-reserved", 5, 5, 32'hC0);
        get_resp(d, ts, s);
        chk(d == 32'hC0 && ts == 13, "R9 reserved load", {d, ts}, {32'hC0, 16'd13});
        issue(6, C, 32'hC1);
        get_resp(d, ts, s);
        chk(!s && d == 0 && ts == 14, "R10 sc success", {d, ts}, {32'h0, 16'd14});
        chk(ts_max == 14, "R6 ts_max after sc", ts_max, 14);
        wb(C, 1, h, d, w, r);
        chk(h && d == 32'hC1 && w == 14 && r == 14, "R10 sc wrote version", {d, w}, {32'hC1, 16'd14});
    endtask

    task automatic t_lrsc_fail;
        logic [DW-1:0] d; logic [TSW-1:0] ts, w, r; bit s, h;
        issue(5, C, 0);
        serve(1, 13, "R9 load-reserved again", 14, 14, 32'hC1);
        get_resp(d, ts, s);
        wb(C, 1, h, d, w, r);
        issue(6, C, 32'hC9);
        serve(1, 13, "R3 sc refetch", 20, 20, 32'hC2);
        get_resp(d, ts, s);
        chk(d == 1, "R11 sc fails on new version", d, 1);
        chk(ts_max == 14, "R11 ts_max unchanged", ts_max, 14);
        issue(0, C, 0);
        get_resp(d, ts, s);
        chk(!s && d == 32'hC2 && ts == 20, "R11 failed sc wrote nothing", d, 32'hC2);
    endtask

    task automatic t_lrsc_regrant;
        logic [DW-1:0] d; logic [TSW-1:0] ts, w, r; bit s, h;
        issue(5, C, 0);
        get_resp(d, ts, s);
        chk(!s && d == 32'hC2 && ts == 20, "R9 reserve on owned line", d, 32'hC2);
        wb(C, 0, h, d, w, r);
        chk(h && w == 20 && r == 20, "R12 downgrade reply lease", {w, r}, {16'd20, 16'd20});
        issue(6, C, 32'hC3);
        serve(1, 13, "R3 sc after downgrade", 20, 20, 32'hC2);
        get_resp(d, ts, s);
        chk(d == 0 && ts == 21, "R10 sc same version regrant", {d, ts}, {32'h0, 16'd21});
        issue(6, C, 32'hC4);
        get_resp(d, ts, s);
        chk(!s && d == 1, "R11 sc without reservation", {s, d}, {1'b0, 32'h1});
        issue(0, C, 0);
        get_resp(d, ts, s);
        chk(d == 32'hC3 && ts == 21, "R11 data kept after refused sc", d, 32'hC3);
    endtask

    task automatic t_wb_miss;
        logic [DW-1:0] d; logic [TSW-1:0] w, r; bit h;
        wb(E, 1, h, d, w, r);
        chk(!h, "R12 writeback to absent line", h, 0);
        chk(ts_max == 21, "R6 final ts_max", ts_max, 21);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_store_first();
        t_loads();
        t_order_regs();
        t_lrsc_ok();
        t_lrsc_fail();
        t_lrsc_regrant();
        t_wb_miss();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule